// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single output line. Software writes a word into a holding register. On the next bit-rate tick the word moves into a separate shift register, and the frame goes out one bit per tick. Because there are two registers, software can place the next word in the holding register while the current frame is still being sent. That next word then follows the stop bit with no idle time between frames.

A control byte enables the transmitter and selects 8-bit or 9-bit frames. In 9-bit mode it also supplies the extra data bit. Nothing in the block generates that bit, so software can use it for parity or for address marking. The block reports two flags. The holding-empty flag tells software when it may write the next word and is meant to drive an interrupt. The shift-empty flag tells software when the line has fully drained and must be polled. The bit-rate tick comes from an external rate generator.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` and `shift_empty` are both 1, and `ctrl_rdata` reads 8'h02.
- R2: The control byte keeps its bit positions: bit 7 clock-source select, bit 6 nine-bit enable, bit 5 transmit enable, bit 4 sync select, bit 3 break request, bit 2 high-speed select, bit 1 shift-empty (read-only), bit 0 ninth data bit. A write stores bits 7..2 and bit 0. Bit 1 always reads back as `shift_empty`. Only bits 6, 5 and 0 affect transmission.
- R3: While transmit enable is 1 and the holding register is empty, a `data_wr` pulse fills the holding register. `hold_empty` reads 0 from the next cycle.
- R4: When the shift register is idle and the holding register is full, the next `baud_tick` loads the shift register. At that tick `txd` goes to 0 (the start bit), `hold_empty` becomes 1 and `shift_empty` becomes 0.
- R5: Each later `baud_tick` moves the line to the next frame bit. The data bits go out least significant first, and then one stop bit at 1.
- R6: When bit 6 was 1 at load time, the frame carries a ninth data bit after the last data bit and before the stop bit. That bit is the value of control bit 0 at the time of the data write.
- R7: If the holding register is full when the tick that ends a stop bit arrives, that same tick starts the next start bit, and `shift_empty` stays 0.
- R8: If the holding register is empty when the tick that ends a stop bit arrives, `shift_empty` becomes 1 and `txd` stays 1.
- R9: A `data_wr` while the holding register is full is ignored. The held word and both flags are unchanged.
- R10: A `data_wr` while transmit enable is 0 is ignored, and `hold_empty` stays 1.
- R11: A control write with bit 5 at 0 aborts any frame. From the next cycle `txd` is 1 and both flags are 1.
- R12: `txd` changes only on a cycle with `baud_tick` or a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rdata | output | 8 | Control byte readback with shift-empty at bit 1 |
| data_wr | input | 1 | Holding register write strobe |
| data_wdata | input | DATA_W | Word to transmit |
| hold_empty | output | 1 | Holding register empty (interrupt flag) |
| shift_empty | output | 1 | Shift register empty |
| txd | output | 1 | Serial output, idles high |

## Verification
The hardest case to reach is the frame boundary. There, the tick that ends a stop bit must load a waiting word, and a third write must arrive while both registers are occupied. The bench loads one word and then refills the holding register straight away. It then issues an extra write that must be dropped. Next it steps the line tick by tick through two chained frames, so both the gapless start bit and the intact second word are compared bit for bit. An abort in the middle of a frame is reached the same way, by sending a control write between two ticks.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

    // Control byte bit positions; the software view depends on them.
    localparam int CB_CLKSRC = 7;
    localparam int CB_NINE   = 6;
    localparam int CB_EN     = 5;
    localparam int CB_SYNC   = 4;
    localparam int CB_BREAK  = 3;
    localparam int CB_HISPD  = 2;
    localparam int CB_SEMPTY = 1;
    localparam int CB_NINTH  = 0;

    typedef struct packed {
        logic clk_src;
        logic nine_en;
        logic tx_en;
        logic sync_sel;
        logic brk_req;
        logic hi_speed;
        logic unused_ro;
        logic ninth;
    } ctrl_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_SEND = 1'b1
    } eng_state_t;

    function automatic logic [7:0] ctrl_readback(input ctrl_t c, input logic sempty);
        logic [7:0] v;
        v = c;
        v[CB_SEMPTY] = sempty;
        return v;
    endfunction

endpackage

// File: rtl/dbtx_ctrl_reg.sv
module dbtx_ctrl_reg
    import dbtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic [7:0]  ctrl_wdata,
    input  logic        shift_empty,
    output ctrl_t       ctrl_q,
    output logic        abort,
    output logic [7:0]  ctrl_rdata
);

    ctrl_t wr_val;

    always_comb begin
        wr_val = ctrl_t'(ctrl_wdata);
        wr_val.unused_ro = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_val;
        end
    end

    assign abort      = ctrl_wr && !ctrl_wdata[CB_EN];
    assign ctrl_rdata = ctrl_readback(ctrl_q, shift_empty);

endmodule

// File: rtl/dbtx_hold_reg.sv
module dbtx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              ninth_in,
    input  logic              tx_en,
    input  logic              abort,
    input  logic              load,
    output logic              full,
    output logic [DATA_W:0]   word
);

    logic accept;

    assign accept = data_wr && tx_en && !full && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (abort) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
            word <= {ninth_in, data_wdata};
        end else if (load) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/dbtx_shift_eng.sv
module dbtx_shift_eng
    import dbtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              nine_en,
    input  logic              abort,
    input  logic              hold_full,
    input  logic [DATA_W:0]   hold_word,
    output logic              load,
    output logic              busy,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(DATA_W + 3);

    eng_state_t         state;
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   bits_left;
    logic               at_stop_end;
    logic [FRAME_W-1:0] frame_new;

    assign at_stop_end = (state == ENG_SEND) && (bits_left == '0);
    assign load = !abort && tx_en && hold_full && baud_tick &&
                  ((state == ENG_IDLE) || at_stop_end);

    always_comb begin
        frame_new = {1'b1, (nine_en ? hold_word[DATA_W] : 1'b1), hold_word[DATA_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state     <= ENG_IDLE;
            frame_q   <= '1;
            bits_left <= '0;
            txd       <= 1'b1;
        end else if (load) begin
            state     <= ENG_SEND;
            frame_q   <= frame_new;
            bits_left <= nine_en ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
            txd       <= 1'b0;
        end else if (baud_tick && state == ENG_SEND) begin
            if (bits_left != '0) begin
                txd       <= frame_q[0];
                frame_q   <= {1'b1, frame_q[FRAME_W-1:1]};
                bits_left <= bits_left - 1'b1;
            end else begin
                state <= ENG_IDLE;
                txd   <= 1'b1;
            end
        end
    end

    assign busy = (state == ENG_SEND);

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wdata,
    output logic [7:0]        ctrl_rdata,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              txd
);

    ctrl_t            ctrl_q;
    logic             abort;
    logic             load;
    logic             busy;
    logic             hold_full;
    logic [DATA_W:0]  hold_word;

    dbtx_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .shift_empty (shift_empty),
        .ctrl_q      (ctrl_q),
        .abort       (abort),
        .ctrl_rdata  (ctrl_rdata)
    );

    dbtx_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .ninth_in   (ctrl_q.ninth),
        .tx_en      (ctrl_q.tx_en),
        .abort      (abort),
        .load       (load),
        .full       (hold_full),
        .word       (hold_word)
    );

    dbtx_shift_eng #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .tx_en     (ctrl_q.tx_en),
        .nine_en   (ctrl_q.nine_en),
        .abort     (abort),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .load      (load),
        .busy      (busy),
        .txd       (txd)
    );

    assign hold_empty  = !hold_full;
    assign shift_empty = !busy;

endmodule

// File: rtl/dbtx_chk.sv
module dbtx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              baud_tick,
    input logic              ctrl_wr,
    input logic [7:0]        ctrl_wdata,
    input logic              data_wr,
    input logic              hold_empty,
    input logic              shift_empty,
    input logic              txd,
    input logic              tx_en,
    input logic [DATA_W:0]   hold_word
);

    a_r12_txd_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && !ctrl_wr) |=> $stable(txd));

    a_r11_abort_clears: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_wdata[5]) |=> (txd && hold_empty && shift_empty));

    a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_empty) |-> !txd);

    a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> txd);

    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!hold_empty && data_wr && !ctrl_wr) |=> $stable(hold_word));

    a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && data_wr && tx_en && !ctrl_wr) |=> !hold_empty);

    a_r10_disabled_write: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && data_wr && !tx_en && !ctrl_wr) |=> hold_empty);

endmodule

bind dbuf_uart_tx dbtx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .baud_tick   (baud_tick),
    .ctrl_wr     (ctrl_wr),
    .ctrl_wdata  (ctrl_wdata),
    .data_wr     (data_wr),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .txd         (txd),
    .tx_en       (ctrl_q.tx_en),
    .hold_word   (hold_word)
);

// File: tb/dbuf_uart_tx_tb.sv
module dbuf_uart_tx_tb;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              baud_tick = 1'b0;
    logic              ctrl_wr = 1'b0;
    logic [7:0]        ctrl_wdata = '0;
    logic [7:0]        ctrl_rdata;
    logic              data_wr = 1'b0;
    logic [DATA_W-1:0] data_wdata = '0;
    logic              hold_empty;
    logic              shift_empty;
    logic              txd;

    int errors = 0;
    int checks = 0;

    always #(CLK_P/2) clk = ~clk;

    dbuf_uart_tx #(.DATA_W(DATA_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .baud_tick   (baud_tick),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .ctrl_rdata  (ctrl_rdata),
        .data_wr     (data_wr),
        .data_wdata  (data_wdata),
        .hold_empty  (hold_empty),
        .shift_empty (shift_empty),
        .txd         (txd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk) begin ctrl_wr = 1'b1; ctrl_wdata = v; end
        @(negedge clk) ctrl_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk) begin data_wr = 1'b1; data_wdata = v; end
        @(negedge clk) data_wr = 1'b0;
    endtask

    // Start bit is already on the line; step through the rest of the frame.
    task automatic run_frame(input logic [7:0] d, input bit nine, input bit nb, input bit chained);
        for (int i = 0; i < DATA_W; i++) begin
            tick();
            chk("R5 data bit", {7'b0, txd}, {7'b0, d[i]});
        end
        if (nine) begin
            tick();
            chk("R6 ninth bit", {7'b0, txd}, {7'b0, nb});
        end
        tick();
        chk("R5 stop bit", {7'b0, txd}, 8'h01);
        chk("R5 busy in stop", {7'b0, shift_empty}, 8'h00);
        tick();
        if (chained) begin
            chk("R7 gapless start", {7'b0, txd}, 8'h00);
            chk("R7 shift stays busy", {7'b0, shift_empty}, 8'h00);
            chk("R7 hold drained", {7'b0, hold_empty}, 8'h01);
        end else begin
            chk("R8 line idle", {7'b0, txd}, 8'h01);
            chk("R8 shift empty", {7'b0, shift_empty}, 8'h01);
        end
    endtask

    task automatic t_reset();
        chk("R1 txd", {7'b0, txd}, 8'h01);
        chk("R1 hold_empty", {7'b0, hold_empty}, 8'h01);
        chk("R1 shift_empty", {7'b0, shift_empty}, 8'h01);
        chk("R1 ctrl_rdata", ctrl_rdata, 8'h02);
    endtask

    task automatic t_ctrl_readback();
        wr_ctrl(8'hDD);
        chk("R2 readback bit1 forced", ctrl_rdata, 8'hDF);
        wr_ctrl(8'h00);
        chk("R2 readback cleared", ctrl_rdata, 8'h02);
    endtask

    task automatic t_disabled_write();
        wr_data(8'h77);
        chk("R10 hold stays empty", {7'b0, hold_empty}, 8'h01);
        tick();
        chk("R10 line idle", {7'b0, txd}, 8'h01);
    endtask

    task automatic t_single8();
        wr_ctrl(8'h20);
        wr_data(8'hA5);
        chk("R3 hold full", {7'b0, hold_empty}, 8'h00);
        chk("R3 shift still empty", {7'b0, shift_empty}, 8'h01);
        chk("R12 no tick no start", {7'b0, txd}, 8'h01);
        tick();
        chk("R4 start low", {7'b0, txd}, 8'h00);
        chk("R4 hold empty", {7'b0, hold_empty}, 8'h01);
        chk("R4 shift busy", {7'b0, shift_empty}, 8'h00);
        chk("R2 bit1 reads busy", ctrl_rdata, 8'h20);
        run_frame(8'hA5, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_nine();
        wr_ctrl(8'h61);
        wr_data(8'h3C);
        wr_ctrl(8'h60);
        tick();
        chk("R4 start low 9b", {7'b0, txd}, 8'h00);
        run_frame(8'h3C, 1'b1, 1'b1, 1'b0);
        wr_data(8'hC1);
        tick();
        run_frame(8'hC1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_chain_and_full();
        wr_ctrl(8'h20);
        wr_data(8'h11);
        tick();
        wr_data(8'h22);
        chk("R3 refill", {7'b0, hold_empty}, 8'h00);
        wr_data(8'h33);
        chk("R9 flags unchanged", {6'b0, hold_empty, shift_empty}, 8'h00);
        run_frame(8'h11, 1'b0, 1'b0, 1'b1);
        run_frame(8'h22, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_abort();
        wr_ctrl(8'h20);
        wr_data(8'h00);
        tick();
        wr_data(8'hFF);
        tick();
        tick();
        chk("R11 pre-abort low", {7'b0, txd}, 8'h00);
        wr_ctrl(8'h00);
        chk("R11 txd high", {7'b0, txd}, 8'h01);
        chk("R11 hold empty", {7'b0, hold_empty}, 8'h01);
        chk("R11 shift empty", {7'b0, shift_empty}, 8'h01);
        wr_ctrl(8'h20);
        tick();
        chk("R11 nothing resumes", {7'b0, txd}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_readback();
        t_disabled_write();
        t_single8();
        t_nine();
        t_chain_and_full();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule